// File: doc/BRIEF.md
# Prescaled Tick Timer with Compare Channels

The block is a timebase for operating-system scheduling and application timeouts. A 32-bit up counter is shared by all channels. It advances once every P+1 system clocks, where P is an 8-bit prescale setting. The divide ratio therefore runs from 1 to 256. Four compare channels each hold a 32-bit value. A channel raises its own sticky flag, and so its own interrupt line, on the increment that brings the counter to that value.

Software drives the block through a simple register port: a valid strobe, a write strobe, a word address and write data, with combinational read data. A debug-halt input freezes the counter and prescaler, but only when the freeze-enable control bit is set.

A small state machine governs the counter. Its states are:

- `ST_IDLE`: counting disabled. The prescaler is cleared and the counter may be written.
- `ST_COUNT`: prescaler and counter advance.
- `ST_HALTED`: prescaler and counter hold.

Its transitions are:

- start: `ST_IDLE` to `ST_COUNT`, when enable is set and no freeze is requested.
- freeze: `ST_IDLE` or `ST_COUNT` to `ST_HALTED`, when enable is set and a freeze is requested.
- thaw: `ST_HALTED` to `ST_COUNT`, when the freeze request drops.
- stop: any state to `ST_IDLE`, when enable is cleared.

A freeze is requested when freeze-enable is set and the debug-halt input is high. The next state is taken from the registered control bits and the debug-halt input, so each change takes effect one clock after it is seen.

Register map (word addresses):

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit 0 enable, bit 1 freeze-enable, bits 15:8 prescale P |
| 1 | Counter | counter value |
| 2 | Flags | bits 3:0, write 1 to clear |
| 3 | Channel enable | bits 3:0 |
| 4+i | Compare i | compare value of channel i, for i = 0 to 3 |

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads as zero, the state is `ST_IDLE`, and all `irq` lines are low.
- R2: While counting, the counter advances by one every P+1 clocks. P is control bits 15:8 and the enable is control bit 0. The first increment lands on the clock edge P+2 cycles after the edge that writes the enable bit to 1.
- R3: The counter wraps from 0xFFFFFFFF to 0 with no extra event; only a compare channel whose value is 0 reacts to the wrap.
- R4: Flag i (address 2, bit i) is set on the increment that makes the counter equal compare i (address 4+i), but only while channel-enable bit i (address 3) is set. Flags never set on a clock without an increment, and `irq[i]` shows flag i.
- R5: Flags are sticky. Writing 1 to flag bit i clears it, and writing 0 leaves it alone. If a clear and a set land on the same edge, the set wins.
- R6: A write to the counter (address 1) takes effect only in `ST_IDLE`, and is ignored in `ST_COUNT` and `ST_HALTED`. Such a write never sets a flag, even when the written value equals an enabled compare value.
- R7: With freeze-enable (control bit 1) set and `dbg_halt` high, the counter and prescaler hold their values.
- R8: With freeze-enable clear, `dbg_halt` has no effect on counting.
- R9: `reg_rdata` shows the addressed register while `reg_valid` is high and `reg_write` is low, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_valid | input | 1 | register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, combinational |
| dbg_halt | input | 1 | debug-halt request |
| irq | output | 4 | per-channel interrupt (sticky flag) |

## Verification
The assertions watch several rules on every clock:

- The counter moves only on a prescaled tick, and then by exactly one.
- It holds through `ST_HALTED` and through a counter write that lands outside `ST_IDLE`.
- No flag rises without a tick, and a clear without a tick removes the flag.
- The freeze-enable bit decides whether `dbg_halt` reaches the state machine.
- Back-to-back ticks appear only when P is zero.

Other behaviours need the bench's scenarios. These are the exact latency of the first increment, the wrap to zero, a flag set that wins over a clear on the same edge, and a write equal to a compare value that raises nothing. The bench also compares every register readback and the interrupt lines against a model of the requirements while the inputs are random.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // counter state machine
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_HALTED = 2'd2
    } ctr_state_e;

    // word addresses
    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_COUNT = 1;
    localparam int unsigned A_FLAG  = 2;
    localparam int unsigned A_CHEN  = 3;
    localparam int unsigned A_CMP0  = 4;

    // control field positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_FRZ_BIT = 1;
    localparam int unsigned CTRL_PS_LSB  = 8;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PS_W   = 8,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    output logic                           ctrl_en,
    output logic                           ctrl_frz,
    output logic [PS_W-1:0]                presc,
    output logic [NUM_CH-1:0]              chen,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp,
    output logic                           cnt_wr,
    output logic [NUM_CH-1:0]              clr_mask
);

    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
    localparam logic [ADDR_W-1:0] AD_FLAG  = ADDR_W'(A_FLAG);
    localparam logic [ADDR_W-1:0] AD_CHEN  = ADDR_W'(A_CHEN);

    logic wr_ctrl;
    logic wr_chen;

    assign wr_ctrl  = wr_en && (addr == AD_CTRL);
    assign wr_chen  = wr_en && (addr == AD_CHEN);
    assign cnt_wr   = wr_en && (addr == AD_COUNT);
    assign clr_mask = (wr_en && (addr == AD_FLAG)) ? wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_frz <= 1'b0;
            presc    <= '0;
        end else if (wr_ctrl) begin
            ctrl_en  <= wdata[CTRL_EN_BIT];
            ctrl_frz <= wdata[CTRL_FRZ_BIT];
            presc    <= wdata[CTRL_PS_LSB +: PS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chen <= '0;
        end else if (wr_chen) begin
            chen <= wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_en && (addr == ADDR_W'(A_CMP0 + ch))) begin
                    cmp[ch] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/tick_timer_ctr.sv
module tick_timer_ctr
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             ctrl_frz,
    input  logic             dbg_halt,
    input  logic [PS_W-1:0]  presc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_inc,
    output logic             tick,
    output ctr_state_e       state
);

    ctr_state_e       state_q, state_d;
    logic [PS_W-1:0]  pcnt_q, pcnt_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             halt_req;

    assign halt_req  = ctrl_frz && dbg_halt;
    assign count_inc = count_q + 1'b1;
    assign count     = count_q;
    assign state     = state_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_en) begin
                    state_d = halt_req ? ST_HALTED : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!ctrl_en) begin
                    state_d = ST_IDLE;
                end else if (halt_req) begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (!ctrl_en) begin
                    state_d = ST_IDLE;
                end else if (!halt_req) begin
                    state_d = ST_COUNT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state datapath outputs
    always_comb begin
        tick    = 1'b0;
        pcnt_d  = pcnt_q;
        count_d = count_q;
        unique case (state_q)
            ST_IDLE: begin
                pcnt_d = '0;
                if (cnt_wr) begin
                    count_d = wdata;
                end
            end
            ST_COUNT: begin
                if (pcnt_q >= presc) begin
                    tick    = 1'b1;
                    pcnt_d  = '0;
                    count_d = count_inc;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            ST_HALTED: begin
                pcnt_d  = pcnt_q;
                count_d = count_q;
            end
            default: begin
                pcnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q  <= '0;
            count_q <= '0;
        end else begin
            pcnt_q  <= pcnt_d;
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/tick_timer_cmp.sv
module tick_timer_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] next_count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             ch_en,
    input  logic             clr,
    output logic             flag
);

    logic hit;

    assign hit = tick && ch_en && (next_count == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= hit | (flag & ~clr);
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PS_W   = 8,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              dbg_halt,
    output logic [NUM_CH-1:0] irq
);

    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
    localparam logic [ADDR_W-1:0] AD_FLAG  = ADDR_W'(A_FLAG);
    localparam logic [ADDR_W-1:0] AD_CHEN  = ADDR_W'(A_CHEN);

    logic                         wr_en;
    logic                         rd_en;
    logic                         ctrl_en;
    logic                         ctrl_frz;
    logic [PS_W-1:0]              presc;
    logic [NUM_CH-1:0]            chen;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    logic                         cnt_wr;
    logic [NUM_CH-1:0]            clr_mask;
    logic [CNT_W-1:0]             count;
    logic [CNT_W-1:0]             count_inc;
    logic                         tick;
    ctr_state_e                   ctr_state;
    logic [NUM_CH-1:0]            flags;

    assign wr_en = reg_valid && reg_write;
    assign rd_en = reg_valid && !reg_write;

    tick_timer_regs #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl_en (ctrl_en),
        .ctrl_frz(ctrl_frz),
        .presc   (presc),
        .chen    (chen),
        .cmp     (cmp),
        .cnt_wr  (cnt_wr),
        .clr_mask(clr_mask)
    );

    tick_timer_ctr #(
        .CNT_W(CNT_W),
        .PS_W (PS_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .ctrl_frz (ctrl_frz),
        .dbg_halt (dbg_halt),
        .presc    (presc),
        .cnt_wr   (cnt_wr),
        .wdata    (reg_wdata),
        .count    (count),
        .count_inc(count_inc),
        .tick     (tick),
        .state    (ctr_state)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tick_timer_cmp #(
            .CNT_W(CNT_W)
        ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .next_count(count_inc),
            .cmp_val   (cmp[g]),
            .ch_en     (chen[g]),
            .clr       (clr_mask[g]),
            .flag      (flags[g])
        );
    end

    assign irq = flags;

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            if (reg_addr == AD_CTRL) begin
                reg_rdata[CTRL_EN_BIT]             = ctrl_en;
                reg_rdata[CTRL_FRZ_BIT]            = ctrl_frz;
                reg_rdata[CTRL_PS_LSB +: PS_W]     = presc;
            end else if (reg_addr == AD_COUNT) begin
                reg_rdata = count;
            end else if (reg_addr == AD_FLAG) begin
                reg_rdata[NUM_CH-1:0] = flags;
            end else if (reg_addr == AD_CHEN) begin
                reg_rdata[NUM_CH-1:0] = chen;
            end else begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (reg_addr == ADDR_W'(A_CMP0 + ch)) begin
                        reg_rdata = cmp[ch];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PS_W   = 8,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_halt,
    input logic              tick,
    input ctr_state_e        state,
    input logic [CNT_W-1:0]  count,
    input logic [NUM_CH-1:0] flags,
    input logic              ctrl_en,
    input logic              ctrl_frz,
    input logic [PS_W-1:0]   presc,
    input logic [NUM_CH-1:0] clr_mask
);

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc != '0) |=> (!tick || presc == '0));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !tick) |=> $stable(count));

    // R7
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |=> $stable(count));

    // R7
    freeze_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_frz && dbg_halt) |=> (state == ST_HALTED));

    // R8
    halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !ctrl_frz) |=> (state == ST_COUNT));

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((flags & ~$past(flags)) == '0));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask != '0) && !tick) |=> ((flags & $past(clr_mask)) == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W (CNT_W),
    .PS_W  (PS_W),
    .NUM_CH(NUM_CH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbg_halt(dbg_halt),
    .tick    (tick),
    .state   (ctr_state),
    .count   (count),
    .flags   (flags),
    .ctrl_en (ctrl_en),
    .ctrl_frz(ctrl_frz),
    .presc   (presc),
    .clr_mask(clr_mask)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_halt = 1'b0;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;
    bit mon_on   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_valid(reg_valid),
        .reg_write(reg_write),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .dbg_halt (dbg_halt),
        .irq      (irq)
    );

    // reference model built from the requirements
    bit          m_en, m_frz;
    logic [7:0]  m_ps, m_pcnt;
    logic [31:0] m_cnt;
    logic [3:0]  m_flags, m_chen;
    logic [31:0] m_cmp [4];
    int          m_st;   // 0 idle, 1 count, 2 halted

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_frz = 0; m_ps = 0; m_pcnt = 0; m_cnt = 0;
            m_flags = 0; m_chen = 0; m_st = 0;
            for (int i = 0; i < 4; i++) m_cmp[i] = 0;
        end else begin
            logic        wr, tk;
            logic [31:0] nc;
            wr = reg_valid && reg_write;
            tk = (m_st == 1) && (m_pcnt >= m_ps);
            if (wr && reg_addr == 3'd2) m_flags = m_flags & ~reg_wdata[3:0];
            if (tk) begin
                nc = m_cnt + 1;
                for (int i = 0; i < 4; i++)
                    if (m_chen[i] && nc == m_cmp[i]) m_flags[i] = 1'b1;
                m_cnt  = nc;
                m_pcnt = 0;
            end else if (m_st == 0) begin
                m_pcnt = 0;
                if (wr && reg_addr == 3'd1) m_cnt = reg_wdata;
            end else if (m_st == 1) begin
                m_pcnt = m_pcnt + 1;
            end
            m_st = !m_en ? 0 : ((m_frz && dbg_halt) ? 2 : 1);
            if (wr) begin
                case (reg_addr)
                    3'd0: begin m_en = reg_wdata[0]; m_frz = reg_wdata[1]; m_ps = reg_wdata[15:8]; end
                    3'd3: m_chen = reg_wdata[3:0];
                    3'd4, 3'd5, 3'd6, 3'd7: m_cmp[reg_addr - 3'd4] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return {16'd0, m_ps, 6'd0, m_frz, m_en};
            3'd1:    return m_cnt;
            3'd2:    return {28'd0, m_flags};
            3'd3:    return {28'd0, m_chen};
            default: return m_cmp[a - 3'd4];
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // interrupt lines follow the model every cycle (R4)
    always @(negedge clk) begin
        if (mon_on) check("R4 irq vs model", {28'd0, irq}, {28'd0, m_flags});
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] a, b, c;
        int unused_seed;
        unused_seed = $urandom(32'h1234_5678);

        idle(3);
        rst_n = 1'b1;
        idle(1);
        mon_on = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 32'd0, "R1 ctrl");
        rd_chk(3'd1, 32'd0, "R1 count");
        rd_chk(3'd2, 32'd0, "R1 flags");
        rd_chk(3'd3, 32'd0, "R1 chen");
        rd_chk(3'd5, 32'd0, "R1 cmp1");
        check("R1 irq", {28'd0, irq}, 32'd0);

        // R9 no read strobe gives zero
        @(negedge clk);
        reg_valid = 1'b0; reg_addr = 3'd0;
        #1 check("R9 idle rdata", reg_rdata, 32'd0);

        // R6 write taken while idle
        wr(3'd1, 32'd100);
        rd_chk(3'd1, 32'd100, "R6 idle write");

        // R2 prescale 3: first increment 5 edges after the enable write
        wr(3'd0, 32'h0000_0301);
        idle(3);
        rd_chk(3'd1, 32'd100, "R2 before first tick");
        rd_chk(3'd1, 32'd101, "R2 first tick");
        idle(2);
        rd_chk(3'd1, 32'd101, "R2 holds within period");
        rd_chk(3'd1, 32'd102, "R2 second tick");

        // R2 prescale 0: one step per clock
        wr(3'd0, 32'd0);
        idle(2);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd1);
        rd_chk(3'd1, 32'd0, "R2 p0 start");
        rd_chk(3'd1, 32'd1, "R2 p0 first");
        idle(7);
        rd_chk(3'd1, 32'd9, "R2 p0 ninth");

        // R8 halt ignored without freeze enable
        dbg_halt = 1'b1;
        idle(2);
        rd(3'd1, a);
        rd(3'd1, b);
        check("R8 counts through halt", b - a, 32'd1);

        // R7 freeze holds the counter
        wr(3'd0, 32'd3);
        idle(2);
        rd(3'd1, a);
        idle(10);
        rd(3'd1, b);
        check("R7 frozen count", b, a);
        // R6 write ignored while halted
        wr(3'd1, 32'd77);
        rd_chk(3'd1, a, "R6 halted write ignored");
        dbg_halt = 1'b0;
        idle(3);
        rd(3'd1, c);
        check("R7 resumes after thaw", {31'd0, c > a}, 32'd1);

        // R4 compare matches on enabled channels only
        wr(3'd0, 32'd0);
        idle(2);
        wr(3'd2, 32'hF);
        wr(3'd1, 32'd10);
        wr(3'd3, 32'h5);
        wr(3'd4, 32'd12);
        wr(3'd5, 32'd12);
        wr(3'd6, 32'd12);
        wr(3'd7, 32'd3);
        wr(3'd0, 32'd1);
        idle(10);
        check("R4 enabled channels flagged", {28'd0, irq}, 32'h5);
        rd_chk(3'd2, 32'h5, "R4 flag readback");

        // R5 write-one-to-clear, zero has no effect
        wr(3'd2, 32'h1);
        check("R5 clear ch0", {28'd0, irq}, 32'h4);
        wr(3'd2, 32'h0);
        check("R5 zero write", {28'd0, irq}, 32'h4);

        // R6 a counter write equal to a compare sets nothing
        wr(3'd0, 32'd0);
        idle(2);
        wr(3'd2, 32'hF);
        wr(3'd7, 32'd50);
        wr(3'd3, 32'h8);
        wr(3'd1, 32'd50);
        idle(3);
        check("R6 write match no flag", {28'd0, irq}, 32'h0);
        wr(3'd0, 32'd1);
        idle(5);
        check("R6 still no flag after counting", {28'd0, irq}, 32'h0);

        // R3 wrap reaches zero and matches a zero compare only
        wr(3'd0, 32'd0);
        idle(2);
        wr(3'd2, 32'hF);
        wr(3'd1, 32'hFFFF_FFFE);
        wr(3'd4, 32'd0);
        wr(3'd3, 32'h1);
        wr(3'd0, 32'd1);
        idle(5);
        rd_chk(3'd1, 32'd3, "R3 wrapped count");
        check("R3 only zero channel", {28'd0, irq}, 32'h1);

        // R5 set wins over clear on the same edge
        wr(3'd0, 32'd0);
        idle(2);
        wr(3'd2, 32'hF);
        wr(3'd1, 32'd200);
        wr(3'd4, 32'd201);
        wr(3'd3, 32'h1);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'h1);
        check("R5 set beats clear", {28'd0, irq}, 32'h1);

        // random phase against the model
        for (int it = 0; it < 6000; it++) begin
            int op;
            logic [2:0]  ad;
            logic [31:0] d;
            @(negedge clk);
            reg_valid = 1'b0; reg_write = 1'b0;
            if ($urandom % 16 == 0) dbg_halt = ~dbg_halt;
            op = $urandom % 10;
            ad = 3'($urandom % 8);
            case (ad)
                3'd0:    d = {16'd0, 8'($urandom % 4), 6'd0, 2'($urandom)} | (($urandom % 4 != 0) ? 32'd1 : 32'd0);
                3'd2:    d = $urandom % 16;
                3'd3:    d = $urandom % 16;
                3'd1:    d = ($urandom % 2) ? m_cnt + ($urandom % 8) : $urandom;
                default: d = m_cnt + ($urandom % 12);
            endcase
            if (op < 3) begin
                reg_valid = 1'b1; reg_write = 1'b1; reg_addr = ad; reg_wdata = d;
            end else if (op < 8) begin
                reg_valid = 1'b1; reg_write = 1'b0; reg_addr = ad;
                #1 check("R9 random readback", reg_rdata, model_read(ad));
            end
        end
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        idle(2);

        done = 1'b1;
        finish_run();
    end

endmodule